// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Unified Cache

This block is a set-associative cache of 32 KB with 32-byte lines, 1024 lines in all, shared by instruction fetches and data accesses through one request port. Each request carries a virtual address and, alongside it, the physical page number produced by the address translation unit. The set is chosen from the untranslated virtual address bits just above the line offset. The stored tag of each way is a physical page number, and the incoming page number is compared against it. The way count is a parameter, 4 or 8. The capacity stays fixed, so there are 256 sets at 4 ways and 128 sets at 8 ways.

A read hit returns the addressed 32-bit word from the array. A read miss requests the line from memory over a simple request/response interface, collects eight consecutive words, installs the line in a victim way and then answers. Writes are write-through: every write goes to memory, a write hit also updates the cached word, and a write miss leaves the arrays alone. Nothing keeps the cache coherent with other bus masters. Software uses a one-cycle invalidate command, which walks all sets, one per cycle, while the request port is held off.

The controller is a single state machine with these states:
- `ST_IDLE`: accepts a request or an invalidate command.
- `ST_LOOKUP`: compares the tags. It goes to `ST_RESPOND` on a read hit, to `ST_FILL_REQ` on a read miss, and to `ST_WRITE_MEM` on any write.
- `ST_FILL_REQ`: goes to `ST_FILL_WAIT` once memory accepts the request.
- `ST_FILL_WAIT`: goes to `ST_RESPOND` after the eighth beat.
- `ST_WRITE_MEM`: goes to `ST_RESPOND` once memory accepts the write.
- `ST_RESPOND`: goes to `ST_IDLE`.
- `ST_INVAL`: returns to `ST_IDLE` after the last set.

Top module: `vipt_cache`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0, and every line is invalid.
- R2: A read miss issues exactly one memory read. Its address is the page number followed by virtual bits [11:5] and five zero bits. Memory returns eight words, word k at that address plus 4k. The response carries word `vaddr[4:2]` of the line. A memory request holds its address while `mem_req_ready` is low.
- R3: A read hit issues no memory request, and `resp_valid` rises in the second cycle after the accepting edge.
- R4: A hit needs a valid way whose stored page number equals `req_ppn`. The same virtual address with another page number misses and fills.
- R5: Every write issues one memory write at the page number followed by `vaddr[11:2]` and two zero bits, with `req_wdata`. A write miss allocates nothing, so a later read of that line misses.
- R6: A write hit replaces the addressed word in the cached line. A later read returns the new value without a memory read.
- R7: A fill places the line in the lowest-numbered invalid way of the set. When all ways are valid it evicts the way named by the set's round-robin pointer, which starts at 0 and advances by one on each such eviction.
- R8: The set index is `vaddr[12:5]` at 4 ways and `vaddr[11:5]` at 8 ways. Two virtual addresses that differ only in bit 12 use different sets at 4 ways.
- R9: A pulse on `inval_start` while idle holds `req_ready` low for exactly one cycle per set. After that every earlier line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_start | input | 1 | Software command to invalidate all lines |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address (word aligned) |
| req_ppn | input | 20 | Physical page number from translation |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | 32 | Physical byte address |
| mem_req_wdata | output | 32 | Write data to memory |
| mem_resp_valid | input | 1 | Fill beat present |
| mem_resp_rdata | input | 32 | Fill beat data |

## Verification
The hardest situation to reach from the ports is an eviction chosen by the round-robin pointer rather than by an invalid way. The stimulus gets there by reading five different page numbers that share one virtual index. That fills all four ways and forces a replacement. Further reads then show which page number was lost: a hit issues no memory read, and a miss does. The invalidate walk is timed by counting the cycles in which `req_ready` stays low.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_WRITE_MEM,
        ST_RESPOND,
        ST_INVAL
    } cache_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 256,
    parameter int TAG_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  lk_set,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic [WAYS-1:0]          hit_vec,
    output logic [WAYS-1:0]          valid_vec,
    input  logic                     alloc_en,
    input  logic [$clog2(SETS)-1:0]  alloc_set,
    input  logic [$clog2(WAYS)-1:0]  alloc_way,
    input  logic [TAG_W-1:0]         alloc_tag,
    input  logic                     inv_en,
    input  logic [$clog2(SETS)-1:0]  inv_set
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (inv_en) begin
            valid_q[inv_set] <= '0;
        end else if (alloc_en) begin
            valid_q[alloc_set][alloc_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) tag_q[alloc_set][alloc_way] <= alloc_tag;
    end

    assign valid_vec = valid_q[lk_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    // R4
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/vipt_victim_sel.sv
module vipt_victim_sel #(
    parameter int WAYS = 4,
    parameter int SETS = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  set_i,
    input  logic [WAYS-1:0]          valid_vec,
    output logic [$clog2(WAYS)-1:0]  victim_o,
    output logic                     evict_o,
    input  logic                     adv_en,
    input  logic [$clog2(SETS)-1:0]  adv_set
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] rr_q [SETS];

    always_comb begin
        victim_o = rr_q[set_i];
        evict_o  = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                victim_o = WAY_W'(w);
                evict_o  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (adv_en) begin
            rr_q[adv_set] <= rr_q[adv_set] + 1'b1;
        end
    end

    // R7
    victim_invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid_vec) |-> !valid_vec[victim_o]);
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
    parameter int WAYS       = 4,
    parameter int SETS       = 256,
    parameter int LINE_WORDS = 8,
    parameter int WORD_W     = 32
) (
    input  logic                          clk,
    input  logic [$clog2(SETS)-1:0]       rd_set,
    input  logic [$clog2(WAYS)-1:0]       rd_way,
    input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
    output logic [WORD_W-1:0]             rd_data,
    input  logic [$clog2(SETS)-1:0]       wr_set,
    input  logic [$clog2(WAYS)-1:0]       wr_way,
    input  logic                          line_we,
    input  logic [LINE_WORDS*WORD_W-1:0]  line_data,
    input  logic                          word_we,
    input  logic [$clog2(LINE_WORDS)-1:0] word_idx,
    input  logic [WORD_W-1:0]             word_data
);
    localparam int ENTRIES = SETS * WAYS;
    localparam int LINE_W  = LINE_WORDS * WORD_W;

    logic [LINE_W-1:0] lines_q [ENTRIES];

    assign rd_data = lines_q[{rd_set, rd_way}][rd_word*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
        if (line_we) begin
            lines_q[{wr_set, wr_way}] <= line_data;
        end else if (word_we) begin
            lines_q[{wr_set, wr_way}][word_idx*WORD_W +: WORD_W] <= word_data;
        end
    end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_cache_pkg::*;
#(
    parameter int CACHE_BYTES = 32768,
    parameter int LINE_BYTES  = 32,
    parameter int WAYS        = 4,
    parameter int PAGE_BITS   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inval_start,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_vaddr,
    input  logic [ADDR_W-PAGE_BITS-1:0] req_ppn,
    input  logic [WORD_W-1:0]           req_wdata,
    output logic                        resp_valid,
    output logic [WORD_W-1:0]           resp_rdata,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic                        mem_req_write,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [WORD_W-1:0]           mem_req_wdata,
    input  logic                        mem_resp_valid,
    input  logic [WORD_W-1:0]           mem_resp_rdata
);
    localparam int LINES      = CACHE_BYTES / LINE_BYTES;
    localparam int SETS       = LINES / WAYS;
    localparam int SET_W      = $clog2(SETS);
    localparam int WAY_W      = $clog2(WAYS);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_WORDS = LINE_BYTES / (WORD_W / 8);
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int PPN_W      = ADDR_W - PAGE_BITS;
    localparam int LINE_W     = LINE_WORDS * WORD_W;
    localparam int BYTE_SEL_W = $clog2(WORD_W / 8);

    cache_state_e state_q, state_d;

    logic              rq_write;
    logic [ADDR_W-1:0] rq_vaddr;
    logic [PPN_W-1:0]  rq_ppn;
    logic [WORD_W-1:0] rq_wdata;
    logic [WAY_W-1:0]  victim_q;
    logic              evict_q;
    logic [WSEL_W-1:0] beat_q;
    logic [LINE_W-1:0] fill_buf_q;
    logic [LINE_W-1:0] fill_line;
    logic [WORD_W-1:0] rdata_q;
    logic [SET_W-1:0]  inv_cnt_q;

    logic [SET_W-1:0]  cur_set;
    logic [WSEL_W-1:0] word_idx;
    logic [WAYS-1:0]   hit_vec, valid_vec;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim;
    logic              evict;
    logic [WORD_W-1:0] rd_word;
    logic              last_beat, alloc_en, word_we;

    assign cur_set   = rq_vaddr[OFF_W +: SET_W];
    assign word_idx  = rq_vaddr[BYTE_SEL_W +: WSEL_W];
    assign hit       = |hit_vec;
    assign last_beat = (state_q == ST_FILL_WAIT) && mem_resp_valid && (beat_q == WSEL_W'(LINE_WORDS - 1));
    assign alloc_en  = last_beat;
    assign word_we   = (state_q == ST_LOOKUP) && rq_write && hit;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    always_comb begin
        fill_line = fill_buf_q;
        fill_line[beat_q*WORD_W +: WORD_W] = mem_resp_rdata;
    end

    vipt_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(PPN_W)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .lk_set(cur_set), .lk_tag(rq_ppn),
        .hit_vec(hit_vec), .valid_vec(valid_vec),
        .alloc_en(alloc_en), .alloc_set(cur_set), .alloc_way(victim_q), .alloc_tag(rq_ppn),
        .inv_en(state_q == ST_INVAL), .inv_set(inv_cnt_q)
    );

    vipt_victim_sel #(.WAYS(WAYS), .SETS(SETS)) victim_i (
        .clk(clk), .rst_n(rst_n),
        .set_i(cur_set), .valid_vec(valid_vec),
        .victim_o(victim), .evict_o(evict),
        .adv_en(alloc_en && evict_q), .adv_set(cur_set)
    );

    vipt_data_store #(.WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) data_i (
        .clk(clk),
        .rd_set(cur_set), .rd_way(hit_way), .rd_word(word_idx), .rd_data(rd_word),
        .wr_set(cur_set), .wr_way(alloc_en ? victim_q : hit_way),
        .line_we(alloc_en), .line_data(fill_line),
        .word_we(word_we), .word_idx(word_idx), .word_data(rq_wdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (inval_start) state_d = ST_INVAL;
                          else if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:    if (rq_write) state_d = ST_WRITE_MEM;
                          else if (hit) state_d = ST_RESPOND;
                          else state_d = ST_FILL_REQ;
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: if (last_beat) state_d = ST_RESPOND;
            ST_WRITE_MEM: if (mem_req_ready) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            ST_INVAL:     if (inv_cnt_q == SET_W'(SETS - 1)) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE) && !inval_start;
        resp_valid    = (state_q == ST_RESPOND);
        resp_rdata    = rdata_q;
        mem_req_valid = (state_q == ST_FILL_REQ) || (state_q == ST_WRITE_MEM);
        mem_req_write = (state_q == ST_WRITE_MEM);
        mem_req_wdata = rq_wdata;
        if (state_q == ST_WRITE_MEM)
            mem_req_addr = {rq_ppn, rq_vaddr[PAGE_BITS-1:BYTE_SEL_W], BYTE_SEL_W'(0)};
        else
            mem_req_addr = {rq_ppn, rq_vaddr[PAGE_BITS-1:OFF_W], OFF_W'(0)};
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_write   <= 1'b0;
            rq_vaddr   <= '0;
            rq_ppn     <= '0;
            rq_wdata   <= '0;
            victim_q   <= '0;
            evict_q    <= 1'b0;
            beat_q     <= '0;
            fill_buf_q <= '0;
            rdata_q    <= '0;
            inv_cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    inv_cnt_q <= '0;
                    if (req_valid && req_ready) begin
                        rq_write <= req_write;
                        rq_vaddr <= req_vaddr;
                        rq_ppn   <= req_ppn;
                        rq_wdata <= req_wdata;
                    end
                end
                ST_LOOKUP: begin
                    victim_q <= victim;
                    evict_q  <= evict;
                    beat_q   <= '0;
                    rdata_q  <= rq_write ? '0 : rd_word;
                end
                ST_FILL_WAIT: begin
                    if (mem_resp_valid) begin
                        fill_buf_q <= fill_line;
                        beat_q     <= beat_q + 1'b1;
                        if (last_beat) rdata_q <= fill_line[word_idx*WORD_W +: WORD_W];
                    end
                end
                ST_INVAL: inv_cnt_q <= inv_cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // R9
    inval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && inval_start) |=> (state_q == ST_INVAL && !req_ready));

    // R3
    hit_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !rq_write && hit) |=> (resp_valid && !mem_req_valid));

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5
    write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && rq_write) |=> (mem_req_valid && mem_req_write));
endmodule

// File: tb/vipt_cache_tb.sv
`timescale 1ns/1ps
module vipt_cache_tb_top;
    localparam int SETS = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval_start = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [19:0] req_ppn = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_rdata;

    always #2 clk = ~clk;

    vipt_cache dut_i (
        .clk(clk), .rst_n(rst_n), .inval_start(inval_start),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_vaddr(req_vaddr), .req_ppn(req_ppn), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
    );

    // bench memory
    logic [31:0] ref_mem [logic [31:0]];
    int          n_reads = 0, n_writes = 0;
    logic [31:0] last_raddr = '0, last_waddr = '0, last_wdata = '0;
    logic        pend = 1'b0;
    logic [31:0] base = '0;
    int          beat = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return (a * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pend           <= 1'b0;
            mem_resp_valid <= 1'b0;
            mem_resp_rdata <= '0;
        end else begin
            mem_resp_valid <= 1'b0;
            if (pend) begin
                mem_resp_valid <= 1'b1;
                mem_resp_rdata <= mem_word(base + 32'(beat * 4));
                beat <= beat + 1;
                if (beat == 7) pend <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    n_writes   <= n_writes + 1;
                    last_waddr <= mem_req_addr;
                    last_wdata <= mem_req_wdata;
                end else begin
                    n_reads    <= n_reads + 1;
                    last_raddr <= mem_req_addr;
                    pend       <= 1'b1;
                    base       <= mem_req_addr;
                    beat       <= 0;
                end
            end
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] va, input logic [19:0] ppn,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int fills, output int writes, output int lat);
        int f0, w0;
        f0 = n_reads;
        w0 = n_writes;
        if (wr) ref_mem[{ppn, va[11:2], 2'b00}] = wd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va; req_ppn = ppn; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!resp_valid && lat < 200);
        rd = resp_rdata;
        fills = n_reads - f0;
        writes = n_writes - w0;
    endtask

    task automatic rd_expect(input logic [31:0] va, input logic [19:0] ppn,
                             input int exp_fill, input string req);
        logic [31:0] rd;
        int f, w, l;
        access(1'b0, va, ppn, 32'h0, rd, f, w, l);
        check(f == exp_fill, req, "fill count", 32'(f), 32'(exp_fill));
        check(rd == mem_word({ppn, va[11:2], 2'b00}), req, "read data",
              rd, mem_word({ppn, va[11:2], 2'b00}));
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] va;
        logic [19:0] ppn;
        logic [31:0] wd;
        logic        exp_fill;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h0000_0104, 20'h12345, 32'h0, 1'b1},         // R2 cold miss
        '{1'b0, 32'h0000_0104, 20'h12345, 32'h0, 1'b0},         // R3 hit
        '{1'b0, 32'h0000_0118, 20'h12345, 32'h0, 1'b0},         // R3 other word
        '{1'b0, 32'h0000_0104, 20'h54321, 32'h0, 1'b1},         // R4 other page
        '{1'b1, 32'h0000_0108, 20'h12345, 32'hDEAD_BEEF, 1'b0}, // R6 write hit
        '{1'b0, 32'h0000_0108, 20'h12345, 32'h0, 1'b0},         // R6 read back
        '{1'b1, 32'h0000_0200, 20'h11111, 32'hCAFE_0001, 1'b0}, // R5 write miss
        '{1'b0, 32'h0000_0200, 20'h11111, 32'h0, 1'b1},         // R5 no allocate
        '{1'b0, 32'h0000_1104, 20'h12345, 32'h0, 1'b1},         // R8 bit 12 set
        '{1'b0, 32'h0000_0104, 20'h12345, 32'h0, 1'b0}          // R8 line kept
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int f, w, l, low;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'h1);
        check(resp_valid == 1'b0, "R1", "resp_valid", 32'(resp_valid), 32'h0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", 32'(mem_req_valid), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic [31:0] waddr;
            v = VECS[i];
            waddr = {v.ppn, v.va[11:2], 2'b00};
            access(v.wr, v.va, v.ppn, v.wd, rd, f, w, l);
            check(f == int'(v.exp_fill), "R2/R4/R8", "fill count", 32'(f), 32'(v.exp_fill));
            if (v.wr) begin
                check(w == 1, "R5", "write count", 32'(w), 32'h1);
                check(last_waddr == waddr, "R5", "write addr", last_waddr, waddr);
                check(last_wdata == v.wd, "R5", "write data", last_wdata, v.wd);
            end else begin
                check(rd == mem_word(waddr), "R6", "read data", rd, mem_word(waddr));
                if (v.exp_fill)
                    check(last_raddr == {v.ppn, v.va[11:5], 5'b0}, "R2", "fill addr",
                          last_raddr, {v.ppn, v.va[11:5], 5'b0});
                else
                    check(l == 2, "R3", "hit latency", 32'(l), 32'h2);
            end
        end

        // R7 replacement in set 20 (vaddr 0x280)
        for (int p = 0; p < 5; p++) rd_expect(32'h0000_0284, 20'h20000 + 20'(p), 1, "R7");
        for (int p = 1; p < 5; p++) rd_expect(32'h0000_0284, 20'h20000 + 20'(p), 0, "R7");
        rd_expect(32'h0000_0284, 20'h20000, 1, "R7");
        rd_expect(32'h0000_0284, 20'h20001, 1, "R7");
        rd_expect(32'h0000_0284, 20'h20003, 0, "R7");
        rd_expect(32'h0000_0284, 20'h20002, 1, "R7");

        // R9 invalidate-all
        @(negedge clk);
        inval_start = 1'b1;
        @(posedge clk);
        #1 inval_start = 1'b0;
        low = 0;
        @(negedge clk);
        while (!req_ready && low < 1000) begin
            low++;
            @(negedge clk);
        end
        check(low == SETS, "R9", "ready-low cycles", 32'(low), 32'(SETS));
        rd_expect(32'h0000_0104, 20'h12345, 1, "R9");
        rd_expect(32'h0000_0284, 20'h20003, 1, "R9");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule